// File: doc/BRIEF.md
# Multi-core interrupt steering router

This block gathers the interrupt sources that belong to a cluster of four processor cores and turns them into one normal (IRQ) and one fast (FIQ) interrupt line per core. Each core has four level-sensitive local timer lines and four mailbox-pending flags. One control byte per core and per source group chooses, for each of those sources, whether it reaches the core as a fast interrupt, as a normal interrupt, or not at all. The cluster also receives one shared upstream IRQ line and one shared upstream FIQ line. A routing register sends each of these to a single core of software's choosing.

Software sees the block through a 32-bit register port using valid, write, address and write-data signals. Read data appears one cycle after the request. Besides the routing and control registers, every core has a read-only IRQ-source word and a read-only FIQ-source word. These words show which sources are driving that core right now. A core's output line is high whenever its source word is nonzero. Status words and output lines are registered, so they follow input and register changes one clock later and never glitch.

Top module: `core_irq_steer`

## Requirements
- R1: Reset clears the routing register, every timer control byte and every mailbox control byte, and holds all core output lines low.
- R2: The routing register sits at offset 0x0C. Bits [1:0] name the core that receives the upstream IRQ and bits [3:2] name the core that receives the upstream FIQ. A read returns these two fields with every other bit zero.
- R3: Core c's timer control byte sits at 0x40+4*c, and only write-data bits [7:0] are stored. Bit n enables normal delivery of timer line n and bit n+4 enables fast delivery of it, for n = 0..3.
- R4: Core c's mailbox control byte sits at 0x50+4*c and uses the same layout as R3 for mailbox flag n.
- R5: An active source whose fast and normal enables are both set appears only in the FIQ-source word. An active source with neither enable set appears in neither word.
- R6: Core c's IRQ-source word is read at 0x60+4*c and its FIQ-source word at 0x70+4*c. Bits 0–3 are timer lines 0–3, bits 4–7 are mailbox flags 0–3 and bit 8 is the upstream line. Bits 9–11 and all higher bits always read zero. The words follow the current input levels, and a source that drops clears its bit.
- R7: The upstream IRQ sets bit 8 only in the IRQ-source word of the core named in the routing register. The upstream FIQ does the same for the FIQ-source word.
- R8: core_irq[c] is high exactly when core c's IRQ-source word is nonzero, and core_fiq[c] likewise for its FIQ-source word. Both lines change on the first clock edge after the input or register change that causes them.
- R9: A read of an unmapped or misaligned offset returns zero. A write to an unmapped, misaligned or status offset changes no register.
- R10: Read data is valid in the cycle after a read request and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_vld | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| tmr_lvl | input | 16 | Timer lines, four per core, core c at [4c+3:4c] |
| mbx_pend | input | 16 | Mailbox-pending flags, four per core, core c at [4c+3:4c] |
| up_irq | input | 1 | Shared upstream normal interrupt |
| up_fiq | input | 1 | Shared upstream fast interrupt |
| core_irq | output | 4 | Normal interrupt line per core |
| core_fiq | output | 4 | Fast interrupt line per core |

## Verification
The hardest case to reach is one where several sources of the same core are active at once while their control byte mixes fast-only, normal-only, both-enabled and disabled settings. Only then do the fast-wins rule and the masking rule show up side by side in both source words. The stimulus table sets a core's two control bytes and its source levels together and reads back both words for each entry. The control patterns mix the enables across the four sources, and one entry turns both enables on for some mailbox flags and neither on for others. Directed steps then check the upstream routing to two different cores, the exact clock edge on which an output rises, and the clearing of a bit when its source drops.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

    localparam int NUM_CORES = 4;
    localparam int SRC_N     = 4;
    localparam int CTL_W     = 2 * SRC_N;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int SEL_W     = 2;

    localparam int TMR_LSB   = 0;
    localparam int MBX_LSB   = TMR_LSB + SRC_N;
    localparam int UP_BIT    = MBX_LSB + SRC_N;

    localparam logic [ADDR_W-1:0] OFS_ROUTE = 8'h0C;
    localparam logic [3:0] PAGE_LOW  = 4'h0;
    localparam logic [3:0] PAGE_TCTL = 4'h4;
    localparam logic [3:0] PAGE_MCTL = 4'h5;
    localparam logic [3:0] PAGE_ISRC = 4'h6;
    localparam logic [3:0] PAGE_FSRC = 4'h7;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_ROUTE,
        RK_TCTL,
        RK_MCTL,
        RK_ISRC,
        RK_FSRC
    } reg_kind_e;

endpackage

// File: rtl/steer_regs.sv
module steer_regs
    import irq_steer_pkg::*;
#(
    parameter int N_CORES = NUM_CORES
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 bus_vld,
    input  logic                                 bus_wr,
    input  logic [ADDR_W-1:0]                    bus_addr,
    input  logic [DATA_W-1:0]                    bus_wdata,
    output logic [DATA_W-1:0]                    bus_rdata,
    input  logic [N_CORES-1:0][DATA_W-1:0]       stat_irq,
    input  logic [N_CORES-1:0][DATA_W-1:0]       stat_fiq,
    output logic [SEL_W-1:0]                     route_irq,
    output logic [SEL_W-1:0]                     route_fiq,
    output logic [N_CORES-1:0][CTL_W-1:0]        tctl,
    output logic [N_CORES-1:0][CTL_W-1:0]        mctl
);

    reg_kind_e              kind;
    logic [SEL_W-1:0]       idx;
    logic [DATA_W-1:0]      rd_val;
    logic [DATA_W-1:0]      rdata_q;
    logic [SEL_W-1:0]       route_irq_q, route_fiq_q;
    logic [N_CORES-1:0][CTL_W-1:0] tctl_q, mctl_q;
    logic                   unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CTL_W];
    assign idx = bus_addr[3:2];

    // Offset decode: aligned accesses only, per-core pages indexed by addr[3:2]
    always_comb begin
        kind = RK_NONE;
        if (bus_addr[1:0] == 2'b00 && int'(idx) < N_CORES) begin
            unique case (bus_addr[7:4])
                PAGE_LOW:  kind = (bus_addr == OFS_ROUTE) ? RK_ROUTE : RK_NONE;
                PAGE_TCTL: kind = RK_TCTL;
                PAGE_MCTL: kind = RK_MCTL;
                PAGE_ISRC: kind = RK_ISRC;
                PAGE_FSRC: kind = RK_FSRC;
                default:   kind = RK_NONE;
            endcase
        end
    end

    always_comb begin
        rd_val = '0;
        unique case (kind)
            RK_ROUTE: rd_val[2*SEL_W-1:0] = {route_fiq_q, route_irq_q};
            RK_TCTL:  rd_val[CTL_W-1:0]   = tctl_q[idx];
            RK_MCTL:  rd_val[CTL_W-1:0]   = mctl_q[idx];
            RK_ISRC:  rd_val              = stat_irq[idx];
            RK_FSRC:  rd_val              = stat_fiq[idx];
            default:  rd_val              = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_irq_q <= '0;
            route_fiq_q <= '0;
            tctl_q      <= '0;
            mctl_q      <= '0;
            rdata_q     <= '0;
        end else if (bus_vld) begin
            if (bus_wr) begin
                unique case (kind)
                    RK_ROUTE: begin
                        route_irq_q <= bus_wdata[SEL_W-1:0];
                        route_fiq_q <= bus_wdata[2*SEL_W-1:SEL_W];
                    end
                    RK_TCTL: tctl_q[idx] <= bus_wdata[CTL_W-1:0];
                    RK_MCTL: mctl_q[idx] <= bus_wdata[CTL_W-1:0];
                    default: ;
                endcase
            end else begin
                rdata_q <= rd_val;
            end
        end
    end

    assign bus_rdata = rdata_q;
    assign route_irq = route_irq_q;
    assign route_fiq = route_fiq_q;
    assign tctl      = tctl_q;
    assign mctl      = mctl_q;

    a_r2_route_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && !bus_wr && kind == RK_ROUTE) |=> (bus_rdata[DATA_W-1:2*SEL_W] == '0));

    a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && !bus_wr && kind == RK_NONE) |=> (bus_rdata == '0));

    a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_vld && !bus_wr) |=> $stable(bus_rdata));

endmodule

// File: rtl/steer_lane.sv
module steer_lane
    import irq_steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  tmr_lvl,
    input  logic [SRC_N-1:0]  mbx_pend,
    input  logic [CTL_W-1:0]  tctl,
    input  logic [CTL_W-1:0]  mctl,
    input  logic              up_irq_hit,
    input  logic              up_fiq_hit,
    output logic [DATA_W-1:0] stat_irq,
    output logic [DATA_W-1:0] stat_fiq,
    output logic              out_irq,
    output logic              out_fiq
);

    // Split one source group by its control byte: fast enable wins over normal
    function automatic logic [CTL_W-1:0] steer_group(
        input logic [SRC_N-1:0] lvl,
        input logic [CTL_W-1:0] ctl
    );
        logic [SRC_N-1:0] fast, norm;
        fast = lvl & ctl[CTL_W-1:SRC_N];
        norm = lvl & ctl[SRC_N-1:0] & ~ctl[CTL_W-1:SRC_N];
        return {fast, norm};
    endfunction

    logic [CTL_W-1:0]  tmr_split, mbx_split;
    logic [DATA_W-1:0] irq_nxt, fiq_nxt;
    logic [DATA_W-1:0] stat_irq_q, stat_fiq_q;
    logic              out_irq_q, out_fiq_q;

    always_comb begin
        tmr_split = steer_group(tmr_lvl, tctl);
        mbx_split = steer_group(mbx_pend, mctl);
        irq_nxt = '0;
        fiq_nxt = '0;
        irq_nxt[TMR_LSB +: SRC_N] = tmr_split[SRC_N-1:0];
        fiq_nxt[TMR_LSB +: SRC_N] = tmr_split[CTL_W-1:SRC_N];
        irq_nxt[MBX_LSB +: SRC_N] = mbx_split[SRC_N-1:0];
        fiq_nxt[MBX_LSB +: SRC_N] = mbx_split[CTL_W-1:SRC_N];
        irq_nxt[UP_BIT]           = up_irq_hit;
        fiq_nxt[UP_BIT]           = up_fiq_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_irq_q <= '0;
            stat_fiq_q <= '0;
            out_irq_q  <= 1'b0;
            out_fiq_q  <= 1'b0;
        end else begin
            stat_irq_q <= irq_nxt;
            stat_fiq_q <= fiq_nxt;
            out_irq_q  <= |irq_nxt;
            out_fiq_q  <= |fiq_nxt;
        end
    end

    assign stat_irq = stat_irq_q;
    assign stat_fiq = stat_fiq_q;
    assign out_irq  = out_irq_q;
    assign out_fiq  = out_fiq_q;

    // R5: a local source never shows in both words
    a_r5_fast_excludes_normal: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_irq[UP_BIT-1:0] & stat_fiq[UP_BIT-1:0]) == '0));

    // R5: a timer bit only shows if its line was high and some enable was set
    a_r5_timer_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_irq[SRC_N-1:0] | stat_fiq[SRC_N-1:0]) &
         ~($past(tmr_lvl) & ($past(tctl[SRC_N-1:0]) | $past(tctl[CTL_W-1:SRC_N])))) == '0);

    a_r6_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_irq[DATA_W-1:UP_BIT+1] == '0) && (stat_fiq[DATA_W-1:UP_BIT+1] == '0));

    a_r8_lines_match_words: assert property (@(posedge clk) disable iff (!rst_n)
        (out_irq == (stat_irq != '0)) && (out_fiq == (stat_fiq != '0)));

endmodule

// File: rtl/core_irq_steer.sv
module core_irq_steer
    import irq_steer_pkg::*;
#(
    parameter int N_CORES = NUM_CORES,
    localparam int SRC_BITS = N_CORES * SRC_N
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_vld,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [SRC_BITS-1:0]  tmr_lvl,
    input  logic [SRC_BITS-1:0]  mbx_pend,
    input  logic                 up_irq,
    input  logic                 up_fiq,
    output logic [N_CORES-1:0]   core_irq,
    output logic [N_CORES-1:0]   core_fiq
);

    logic [SEL_W-1:0]               route_irq, route_fiq;
    logic [N_CORES-1:0][CTL_W-1:0]  tctl, mctl;
    logic [N_CORES-1:0][DATA_W-1:0] stat_irq, stat_fiq;
    logic [N_CORES-1:0]             up_irq_col, up_fiq_col;

    steer_regs #(.N_CORES(N_CORES)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_vld   (bus_vld),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .stat_irq  (stat_irq),
        .stat_fiq  (stat_fiq),
        .route_irq (route_irq),
        .route_fiq (route_fiq),
        .tctl      (tctl),
        .mctl      (mctl)
    );

    for (genvar c = 0; c < N_CORES; c++) begin : g_lane
        logic irq_hit, fiq_hit;
        assign irq_hit = up_irq && (int'(route_irq) == c);
        assign fiq_hit = up_fiq && (int'(route_fiq) == c);

        steer_lane lane_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .tmr_lvl    (tmr_lvl[c*SRC_N +: SRC_N]),
            .mbx_pend   (mbx_pend[c*SRC_N +: SRC_N]),
            .tctl       (tctl[c]),
            .mctl       (mctl[c]),
            .up_irq_hit (irq_hit),
            .up_fiq_hit (fiq_hit),
            .stat_irq   (stat_irq[c]),
            .stat_fiq   (stat_fiq[c]),
            .out_irq    (core_irq[c]),
            .out_fiq    (core_fiq[c])
        );

        assign up_irq_col[c] = stat_irq[c][UP_BIT];
        assign up_fiq_col[c] = stat_fiq[c][UP_BIT];
    end

    // R7: each upstream line lands on at most one core
    a_r7_up_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(up_irq_col) && $onehot0(up_fiq_col));

    // R7: no upstream bit without the upstream line one cycle earlier
    a_r7_up_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
        ((!$past(up_irq) -> (up_irq_col == '0)) && (!$past(up_fiq) -> (up_fiq_col == '0))));

endmodule

// File: tb/core_irq_steer_tb.sv
module core_irq_steer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_vld = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] tmr_lvl = '0;
    logic [15:0] mbx_pend = '0;
    logic        up_irq = 1'b0;
    logic        up_fiq = 1'b0;
    logic [3:0]  core_irq, core_fiq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    core_irq_steer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_lvl(tmr_lvl), .mbx_pend(mbx_pend), .up_irq(up_irq), .up_fiq(up_fiq),
        .core_irq(core_irq), .core_fiq(core_fiq)
    );

    // {tctl, tmr, mctl, mbx, expected IRQ word[11:0], expected FIQ word[11:0]} for core 1
    localparam int NV = 8;
    localparam logic [47:0] VECS [NV] = '{
        {8'h01, 4'h1, 8'h00, 4'h0, 12'h001, 12'h000},
        {8'h10, 4'h1, 8'h00, 4'h0, 12'h000, 12'h001},
        {8'h11, 4'h1, 8'h00, 4'h0, 12'h000, 12'h001},
        {8'h00, 4'hF, 8'h00, 4'hF, 12'h000, 12'h000},
        {8'h5A, 4'hF, 8'h00, 4'h0, 12'h00A, 12'h005},
        {8'h00, 4'h0, 8'h0F, 4'h5, 12'h050, 12'h000},
        {8'h0F, 4'h3, 8'hF0, 4'hF, 12'h003, 12'h0F0},
        {8'h00, 4'h0, 8'h33, 4'hF, 12'h000, 12'h030}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_vld = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_vld = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_vld = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: dirty the registers, then reset again
        wr(8'h0C, 32'hF); wr(8'h44, 32'hFF); wr(8'h50, 32'hFF);
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        rd(8'h0C, d); chk("R1", "route after reset", d, 32'h0);
        rd(8'h44, d); chk("R1", "tctl1 after reset", d, 32'h0);
        rd(8'h50, d); chk("R1", "mctl0 after reset", d, 32'h0);
        chk("R1", "lines after reset", {24'h0, core_fiq, core_irq}, 32'h0);

        // Vector table on core 1 (R3, R4, R5, R6, R8)
        for (int v = 0; v < NV; v++) begin
            logic [47:0] e;
            e = VECS[v];
            wr(8'h44, {24'h0, e[47:40]});
            wr(8'h54, {24'h0, e[35:28]});
            tmr_lvl[7:4] = e[39:36];
            mbx_pend[7:4] = e[27:24];
            settle();
            rd(8'h64, d); chk("R3/R4/R5/R6", "core1 irq word", d, {20'h0, e[23:12]});
            rd(8'h74, d); chk("R3/R4/R5/R6", "core1 fiq word", d, {20'h0, e[11:0]});
            chk("R8", "irq lines", {28'h0, core_irq},
                {28'h0, 2'b00, (e[23:12] != 0), 1'b0});
            chk("R8", "fiq lines", {28'h0, core_fiq},
                {28'h0, 2'b00, (e[11:0] != 0), 1'b0});
        end
        tmr_lvl = '0; mbx_pend = '0;
        settle();

        // R3: only low byte stored
        wr(8'h48, 32'hFFFF_FF12);
        rd(8'h48, d); chk("R3", "tctl low byte only", d, 32'h12);

        // R8: exact edge of output change, R6: drop clears
        wr(8'h40, 32'h01);
        settle();
        @(negedge clk); tmr_lvl[0] = 1'b1;
        chk("R8", "line before edge", {31'h0, core_irq[0]}, 32'h0);
        @(negedge clk);
        chk("R8", "line one edge later", {31'h0, core_irq[0]}, 32'h1);
        tmr_lvl[0] = 1'b0;
        @(negedge clk);
        chk("R6", "line clears when source drops", {31'h0, core_irq[0]}, 32'h0);
        settle();
        rd(8'h60, d); chk("R6", "core0 irq word not latched", d, 32'h0);

        // R2, R7: upstream IRQ -> core 1, FIQ -> core 2
        wr(8'h0C, 32'hFFFF_FFF9);
        rd(8'h0C, d); chk("R2", "route readback", d, 32'h9);
        up_irq = 1'b1; up_fiq = 1'b1;
        settle();
        rd(8'h64, d); chk("R7", "core1 irq word", d, 32'h100);
        rd(8'h60, d); chk("R7", "core0 irq word", d, 32'h0);
        rd(8'h78, d); chk("R7", "core2 fiq word", d, 32'h100);
        rd(8'h74, d); chk("R7", "core1 fiq word", d, 32'h0);
        chk("R7", "line pattern", {24'h0, core_fiq, core_irq}, 32'h42);
        up_irq = 1'b0; up_fiq = 1'b0;
        settle();
        chk("R7", "lines after upstream drop", {24'h0, core_fiq, core_irq}, 32'h0);

        // R9: unmapped / misaligned / read-only
        rd(8'h00, d); chk("R9", "read 0x00", d, 32'h0);
        rd(8'h80, d); chk("R9", "read 0x80", d, 32'h0);
        wr(8'h40, 32'h22);
        wr(8'h41, 32'hFF);
        rd(8'h41, d); chk("R9", "misaligned read", d, 32'h0);
        rd(8'h40, d); chk("R9", "misaligned write ignored", d, 32'h22);
        wr(8'h64, 32'hFFFF);
        rd(8'h64, d); chk("R9", "status write ignored", d, 32'h0);
        chk("R9", "lines after status write", {24'h0, core_fiq, core_irq}, 32'h0);

        // R10: read data holds across idle cycles and writes
        rd(8'h0C, d); chk("R10", "route read", d, 32'h9);
        wr(8'h40, 32'h33);
        repeat (2) @(negedge clk);
        chk("R10", "rdata held", bus_rdata, 32'h9);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule